// File: doc/BRIEF.md
# Prioritized Interrupt Cause Selector

This block decides which pending interrupt a hart should take next and produces the cause code for it. Its inputs are the pending interrupt vector, the machine-level delegation mask, the current privilege level, the global machine and supervisor interrupt-enable bits, and a flag that is high while the hart is in debug mode. Its outputs are a one-cycle-registered take strobe and an XLEN-wide cause word.

Selection happens in three steps. First, a candidate group is formed. Interrupts that are not delegated and are enabled at machine level always form the candidate set when that set is non-empty. Only when it is empty are the delegated interrupts considered, and then only if supervisor interrupts are enabled. Second, a fixed class ordering reduces the group to a single class. Third, the lowest set bit of the reduced set is chosen. The trap-entry sequencer that consumes the strobe and cause is outside this block, and so are the interrupt sources.

The selector has no internal sequencing. It is a single register stage after a combinational selection path, so it has no named states or transitions. The only notion of state is the output register, which is cleared by reset and otherwise reloaded on every clock.

Top module: `irq_cause_sel`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it, `take_o` is 0 and `cause_o` is all zeros.
- R2: Interrupt bits whose delegation bit is 0 are candidates only when machine interrupts are enabled. This holds when the privilege (U=0, S=1, M=3) is below 3, or when it equals 3 and `m_ie_i` is 1.
- R3: When any non-delegated pending bit is enabled by R2, only non-delegated bits are candidates. This applies even when a delegated bit belongs to a higher-priority class.
- R4: Delegated pending bits are candidates only when R3 leaves the set empty and supervisor interrupts are enabled. This holds when the privilege is 0, or when it is 1 and `s_ie_i` is 1. At privilege 2 or 3, delegated bits are never taken.
- R5: While `dbg_active_i` is 1, no interrupt is taken, whatever is pending.
- R6: Any candidate at bit 11 or above (the custom class, which includes the machine external bit) wins over all lower-numbered candidates.
- R7: Without custom-class candidates, the external bits (9, 11) win over the software bits (1, 3), and the software bits win over the timer bits (5, 7).
- R8: Within the winning class, the lowest-numbered set bit is chosen.
- R9: When `take_o` is 1, bit XLEN-1 of `cause_o` is 1 and the low bits hold the chosen interrupt number, with all other bits 0. When `take_o` is 0, `cause_o` is 0.
- R10: Outputs reflect the inputs sampled at the previous rising clock edge, with exactly one cycle of latency.
- R11: Candidate bits 0, 2, 4, 6, 8 and 10 belong to no class. They are never taken and do not prevent another class from being taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| pend_i | input | XLEN | Pending interrupt bits |
| deleg_i | input | XLEN | Machine delegation mask (1 = delegated to supervisor) |
| priv_i | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| m_ie_i | input | 1 | Global machine interrupt enable |
| s_ie_i | input | 1 | Global supervisor interrupt enable |
| dbg_active_i | input | 1 | High while the hart is in debug mode |
| take_o | output | 1 | Registered take-interrupt strobe |
| cause_o | output | XLEN | Registered cause: interrupt flag in bit XLEN-1, number below |

## Verification
The assertions assume the inputs are stable and free of X at each rising edge, since each one relates the registered outputs to the inputs of the edge before. The bench changes inputs only on the falling edge and drives every input from time zero, including during reset. All privilege encodings are exercised, including the reserved value 2, and the bench expects the same numeric comparisons there. The randomized stretch mixes delegation masks, enable bits and debug states freely, so every input combination the bench applies is legal for the block.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;

    localparam int unsigned BIT_SSIP = 1;
    localparam int unsigned BIT_MSIP = 3;
    localparam int unsigned BIT_STIP = 5;
    localparam int unsigned BIT_MTIP = 7;
    localparam int unsigned BIT_SEIP = 9;
    localparam int unsigned BIT_MEIP = 11;

    // lowest bit of the custom class (machine external and above)
    localparam int unsigned CUSTOM_LO = BIT_MEIP;

    typedef enum logic [1:0] {
        PRIV_USER  = 2'd0,
        PRIV_SUPER = 2'd1,
        PRIV_RSVD  = 2'd2,
        PRIV_MACH  = 2'd3
    } priv_e;

endpackage

// File: rtl/irq_group_pick.sv
module irq_group_pick
    import irq_sel_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic [XLEN-1:0] pend_i,
    input  logic [XLEN-1:0] deleg_i,
    input  logic [1:0]      priv_i,
    input  logic            m_ie_i,
    input  logic            s_ie_i,
    output logic [XLEN-1:0] m_cand_o,
    output logic [XLEN-1:0] cand_o
);

    logic m_en;
    logic s_en;

    always_comb begin
        m_en = (priv_i < PRIV_MACH) || ((priv_i == PRIV_MACH) && m_ie_i);
        s_en = (priv_i < PRIV_SUPER) || ((priv_i == PRIV_SUPER) && s_ie_i);
    end

    always_comb begin
        m_cand_o = pend_i & ~deleg_i & {XLEN{m_en}};
        if (m_cand_o != '0) begin
            cand_o = m_cand_o;
        end else begin
            cand_o = pend_i & deleg_i & {XLEN{s_en}};
        end
    end

endmodule

// File: rtl/irq_class_reduce.sv
module irq_class_reduce
    import irq_sel_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic [XLEN-1:0] cand_i,
    output logic [XLEN-1:0] reduced_o
);

    logic [XLEN-1:0] custom_mask;
    logic [XLEN-1:0] ext_mask;
    logic [XLEN-1:0] sw_mask;
    logic [XLEN-1:0] tmr_mask;

    for (genvar g = 0; g < XLEN; g++) begin : g_masks
        assign custom_mask[g] = (g >= CUSTOM_LO);
        assign ext_mask[g]    = (g == BIT_SEIP) || (g == BIT_MEIP);
        assign sw_mask[g]     = (g == BIT_SSIP) || (g == BIT_MSIP);
        assign tmr_mask[g]    = (g == BIT_STIP) || (g == BIT_MTIP);
    end

    always_comb begin
        if ((cand_i & custom_mask) != '0) begin
            reduced_o = cand_i & custom_mask;
        end else if ((cand_i & ext_mask) != '0) begin
            reduced_o = cand_i & ext_mask;
        end else if ((cand_i & sw_mask) != '0) begin
            reduced_o = cand_i & sw_mask;
        end else if ((cand_i & tmr_mask) != '0) begin
            reduced_o = cand_i & tmr_mask;
        end else begin
            reduced_o = '0;
        end
    end

endmodule

// File: rtl/irq_lowest_bit.sv
module irq_lowest_bit #(
    parameter int unsigned XLEN = 32,
    localparam int unsigned IDXW = $clog2(XLEN)
) (
    input  logic [XLEN-1:0] vec_i,
    output logic [IDXW-1:0] idx_o,
    output logic            any_o
);

    always_comb begin
        idx_o = '0;
        any_o = 1'b0;
        for (int i = XLEN - 1; i >= 0; i--) begin
            if (vec_i[i]) begin
                idx_o = IDXW'(i);
                any_o = 1'b1;
            end
        end
    end

endmodule

// File: rtl/irq_cause_sel.sv
module irq_cause_sel #(
    parameter int unsigned XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [XLEN-1:0] pend_i,
    input  logic [XLEN-1:0] deleg_i,
    input  logic [1:0]      priv_i,
    input  logic            m_ie_i,
    input  logic            s_ie_i,
    input  logic            dbg_active_i,
    output logic            take_o,
    output logic [XLEN-1:0] cause_o
);

    localparam int unsigned IDXW = $clog2(XLEN);

    logic [XLEN-1:0] m_cand;
    logic [XLEN-1:0] cand;
    logic [XLEN-1:0] reduced;
    logic [IDXW-1:0] win_idx;
    logic            win_any;
    logic            take_d;
    logic [XLEN-1:0] cause_d;

    irq_group_pick #(.XLEN(XLEN)) u_group (
        .pend_i   (pend_i),
        .deleg_i  (deleg_i),
        .priv_i   (priv_i),
        .m_ie_i   (m_ie_i),
        .s_ie_i   (s_ie_i),
        .m_cand_o (m_cand),
        .cand_o   (cand)
    );

    irq_class_reduce #(.XLEN(XLEN)) u_reduce (
        .cand_i    (cand),
        .reduced_o (reduced)
    );

    irq_lowest_bit #(.XLEN(XLEN)) u_lowest (
        .vec_i (reduced),
        .idx_o (win_idx),
        .any_o (win_any)
    );

    always_comb begin
        take_d  = win_any && !dbg_active_i;
        cause_d = '0;
        if (take_d) begin
            cause_d[XLEN-1]   = 1'b1;
            cause_d[IDXW-1:0] = win_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take_o  <= 1'b0;
            cause_o <= '0;
        end else begin
            take_o  <= take_d;
            cause_o <= cause_d;
        end
    end

    AST_CAUSE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> cause_o[XLEN-1]); // R9

    AST_IDLE_CAUSE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !take_o |-> (cause_o == '0)); // R9

    AST_DEBUG_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_active_i |=> !take_o); // R5

    AST_EMPTY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (reduced == '0) |=> !take_o); // R11

    AST_TAKEN_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> (($past(pend_i) >> cause_o[IDXW-1:0]) & XLEN'(1)) != '0); // R8

    AST_MACH_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && $past(m_cand != '0))
            |-> (($past(deleg_i) >> cause_o[IDXW-1:0]) & XLEN'(1)) == '0); // R3

endmodule

// File: tb/tb_irq_cause_sel.sv
module tb_irq_cause_sel;

    localparam int unsigned XLEN       = 32;
    localparam time         CLK_PERIOD = 10ns;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [XLEN-1:0] pend_i = '0;
    logic [XLEN-1:0] deleg_i = '0;
    logic [1:0]      priv_i = 2'd3;
    logic            m_ie_i = 1'b0;
    logic            s_ie_i = 1'b0;
    logic            dbg_active_i = 1'b0;
    logic            take_o;
    logic [XLEN-1:0] cause_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    irq_cause_sel #(.XLEN(XLEN)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .pend_i       (pend_i),
        .deleg_i      (deleg_i),
        .priv_i       (priv_i),
        .m_ie_i       (m_ie_i),
        .s_ie_i       (s_ie_i),
        .dbg_active_i (dbg_active_i),
        .take_o       (take_o),
        .cause_o      (cause_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // behavioural reference built from the requirements
    function automatic void model(input logic [XLEN-1:0] p, input logic [XLEN-1:0] d,
                                  input int pv, input bit mie, input bit sie, input bit dbg,
                                  output bit take, output logic [XLEN-1:0] cause);
        logic [XLEN-1:0] c;
        logic [XLEN-1:0] sel;
        bit m_en;
        bit s_en;
        bit hit;
        m_en = (pv < 3) || (pv == 3 && mie);
        s_en = (pv < 1) || (pv == 1 && sie);
        c = m_en ? (p & ~d) : '0;
        if (c == '0) c = s_en ? (p & d) : '0;
        if (dbg) c = '0;
        sel = '0;
        hit = 1'b0;
        for (int i = 11; i < XLEN; i++) if (c[i]) begin sel[i] = 1'b1; hit = 1'b1; end
        if (!hit && (c[9] || c[11])) begin sel[9] = c[9]; sel[11] = c[11]; hit = 1'b1; end
        if (!hit && (c[1] || c[3])) begin sel[1] = c[1]; sel[3] = c[3]; hit = 1'b1; end
        if (!hit && (c[5] || c[7])) begin sel[5] = c[5]; sel[7] = c[7]; hit = 1'b1; end
        take = 1'b0;
        cause = '0;
        for (int i = 0; i < XLEN; i++) begin
            if (sel[i] && !take) begin
                take = 1'b1;
                cause = (XLEN'(1) << (XLEN - 1)) | XLEN'(i);
            end
        end
    endfunction

    task automatic compare(input bit et, input logic [XLEN-1:0] ec, input string req);
        checks++;
        if (take_o !== et || cause_o !== ec) begin
            fails++;
            $display("FAIL %s: actual take=%0b cause=%h expected take=%0b cause=%h",
                     req, take_o, cause_o, et, ec);
        end
    endtask

    // drive on falling edge, output updates at the rising edge, check on next falling edge
    task automatic apply(input logic [XLEN-1:0] p, input logic [XLEN-1:0] d, input int pv,
                         input bit mie, input bit sie, input bit dbg, input string req);
        bit et;
        logic [XLEN-1:0] ec;
        pend_i = p; deleg_i = d; priv_i = 2'(pv);
        m_ie_i = mie; s_ie_i = sie; dbg_active_i = dbg;
        model(p, d, pv, mie, sie, dbg, et, ec);
        @(negedge clk);
        compare(et, ec, req);
    endtask

    localparam logic [XLEN-1:0] SSIP = XLEN'(1) << 1;
    localparam logic [XLEN-1:0] MSIP = XLEN'(1) << 3;
    localparam logic [XLEN-1:0] STIP = XLEN'(1) << 5;
    localparam logic [XLEN-1:0] MTIP = XLEN'(1) << 7;
    localparam logic [XLEN-1:0] SEIP = XLEN'(1) << 9;
    localparam logic [XLEN-1:0] MEIP = XLEN'(1) << 11;

    initial begin
        // R1: reset state
        pend_i = MEIP; m_ie_i = 1'b1;
        repeat (3) @(negedge clk);
        compare(1'b0, '0, "R1 in reset");
        rst_n = 1'b1;
        apply('0, '0, 3, 1, 0, 0, "R1 after reset");

        // R2: machine enable
        apply(MTIP, '0, 3, 0, 0, 0, "R2 M mode disabled");
        apply(MTIP, '0, 3, 1, 0, 0, "R2 M mode enabled");
        apply(MTIP, '0, 1, 0, 0, 0, "R2 S mode");
        apply(MTIP, '0, 0, 0, 0, 0, "R2 U mode");
        apply(MTIP, '0, 2, 0, 0, 0, "R2 reserved priv");

        // R3: machine group first
        apply(MTIP | SEIP, SEIP, 0, 0, 1, 0, "R3 timer beats delegated external");
        apply(MSIP | SSIP, SSIP, 1, 0, 1, 0, "R3 S mode machine software");

        // R4: supervisor enable for delegated bits
        apply(SSIP, SSIP, 1, 0, 0, 0, "R4 S mode sie off");
        apply(SSIP, SSIP, 1, 0, 1, 0, "R4 S mode sie on");
        apply(SSIP, SSIP, 0, 0, 0, 0, "R4 U mode");
        apply(SSIP, SSIP, 3, 1, 1, 0, "R4 M mode");
        apply(MSIP | SEIP, SEIP, 3, 0, 1, 0, "R4 masked machine set");

        // R5: debug blocks
        apply(MEIP, '0, 0, 1, 1, 1, "R5 debug active");
        apply(MEIP, '0, 0, 1, 1, 0, "R5 debug released");

        // R6: custom class
        apply(MEIP | (XLEN'(1) << 16), '0, 3, 1, 0, 0, "R6 MEIP with custom");
        apply(SEIP | (XLEN'(1) << 20), '0, 3, 1, 0, 0, "R6 custom over SEIP");
        apply(SEIP | MTIP | (XLEN'(1) << 20), '0, 3, 1, 0, 0, "R6 custom over all");

        // R7: class order
        apply(SEIP | MSIP, '0, 3, 1, 0, 0, "R7 external over software");
        apply(SSIP | MTIP, '0, 3, 1, 0, 0, "R7 software over timer");
        apply(STIP | MTIP, '0, 3, 1, 0, 0, "R7 timer pair");

        // R8: lowest bit
        apply((XLEN'(1) << 12) | (XLEN'(1) << 20) | (XLEN'(1) << 31), '0, 3, 1, 0, 0, "R8 lowest custom");
        apply(MSIP | SSIP | STIP, '0, 3, 1, 0, 0, "R8 lowest software");

        // R9: cause format at the top bit
        apply(XLEN'(1) << 31, '0, 3, 1, 0, 0, "R9 top interrupt");

        // R11: unclassified bits
        apply(XLEN'(32'h0000_0555), '0, 3, 1, 0, 0, "R11 only unclassified");
        apply(XLEN'(32'h0000_0001) | MTIP, '0, 3, 1, 0, 0, "R11 unclassified plus timer");

        // R10: one-cycle latency with inputs changing every cycle
        for (int k = 0; k < 16; k++) begin
            apply((k % 2 == 0) ? MEIP : '0, '0, 3, 1, 0, 0, "R10 toggle");
        end

        // randomized mix (R2 R3 R4 R6 R7 R8)
        for (int k = 0; k < 3000; k++) begin
            logic [XLEN-1:0] rp;
            logic [XLEN-1:0] rd;
            rp = XLEN'($urandom);
            if (k % 3 != 0) rp = rp & XLEN'(32'h0000_0FFF);
            rd = XLEN'($urandom);
            apply(rp, rd, int'($urandom_range(0, 3)), bit'($urandom_range(0, 1)),
                  bit'($urandom_range(0, 1)), ($urandom_range(0, 7) == 0), "R4 random mix");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog all: actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule